// File: doc/BRIEF.md
# Tile Supply and Clock Sequencer

This block decides which supply a processor tile runs from and what divider its local oscillator uses. It also carries out every change of supply in a fixed, safe order. A request names a supply state (high rail, low rail, or disconnected) and a clock divider. The request can come from one of three sources. The first is a static setting held on input pins. The second is a one-cycle software strobe. The third is a hardware policy that watches how full the tile's input FIFO is and how many cycles the core spends stalled in each 256-cycle window.

A change of supply first halts the oscillator. It then opens every power-gate segment and drops both rail selects. Next it selects the new rail and closes the gate segments one at a time, at a programmable step interval, so that inrush current stays bounded. Only once all segments conduct does it restart the clock with the new divider. Powering off stops after the cut, and the clock stays halted. A request that keeps the current supply and only changes the divider is applied at once, with no sequence. The analog switches and the oscillator lie outside the block and are driven through plain control outputs.

Top module: `tile_pwr_ctl`

## Requirements
- R1: After reset the block reports supply code 0 (off), both rail selects low, all gate segments open (0), the oscillator halted, divider 0 and not busy.
- R2: src_sel picks the request source. Code 0 is the static pins, applied whenever they differ from the settled state. Code 1 is the software strobe sw_valid. Code 2 is the hardware policy. Code 3 raises no request. Supply code 3 is invalid, and a request carrying it is dropped. Supply codes are 0 = off, 1 = low rail, 2 = high rail.
- R3: A request accepted on edge e0 that connects a rail runs in this order. The oscillator halts at e0. Gates and rails are all off at e1. The target rail is selected at e2. One further gate segment closes every step_interval+1 cycles. One edge after the last of the 48 segments closes, the halt is released and the new divider is applied. busy is high for exactly 3 + 48*(step_interval+1) cycles.
- R4: A request to power off drops all gates and rails one edge after the halt. It keeps the oscillator halted, applies the new divider and holds busy for exactly 2 cycles.
- R5: The two rail selects are never high together, and the gate segments are all open whenever neither rail is selected.
- R6: The number of closed gate segments never rises by more than one per cycle.
- R7: A request whose supply equals the settled supply but whose divider differs updates osc_div on the accepting edge, without raising busy or touching the halt.
- R8: Requests that arrive while busy is high are dropped and not queued. This includes the final, settling cycle. The target of a running sequence never changes.
- R9: At the close of every 256-cycle window the policy decides as follows. It chooses UP (high rail, fast_div) if fifo_fill > fill_hi_th or the window's stall count < stall_lo_th. Otherwise it chooses DOWN (low rail, slow_div) if fifo_fill < fill_lo_th and the stall count > stall_hi_th. Otherwise it chooses hold.
- R10: The hardware policy issues a request only when two consecutive windows reach the same decision, and that decision is not hold.
- R11: The oscillator halt is high in every cycle of a supply transition, and it is never released before all gate segments conduct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Request source: 0 static, 1 software, 2 hardware, 3 none |
| static_supply | input | 2 | Static supply code |
| static_div | input | DIVW | Static divider |
| sw_valid | input | 1 | Software command strobe |
| sw_supply | input | 2 | Software supply code |
| sw_div | input | DIVW | Software divider |
| fifo_fill | input | FILLW | Input FIFO occupancy |
| core_stall | input | 1 | Core stalled this cycle |
| fill_hi_th | input | FILLW | Upper fullness threshold |
| fill_lo_th | input | FILLW | Lower fullness threshold |
| stall_hi_th | input | log2(WIN)+1 | Stall count above which the tile may slow down |
| stall_lo_th | input | log2(WIN)+1 | Stall count below which the tile speeds up |
| fast_div | input | DIVW | Divider paired with the high rail |
| slow_div | input | DIVW | Divider paired with the low rail |
| step_interval | input | STEPW | Extra cycles between gate segment steps |
| rail_hi | output | 1 | Connect the high supply rail |
| rail_lo | output | 1 | Connect the low supply rail |
| gate_en | output | NSEG | Power-gate segment enables |
| osc_halt | output | 1 | Halt the local oscillator |
| osc_div | output | DIVW | Oscillator divider |
| busy | output | 1 | Supply transition in progress |
| supply_state | output | 2 | Settled supply code |

## Verification
Two events can fall on the same edge: the settling of a transition and the arrival of a new request. A software strobe is placed so that it is sampled on the very edge that releases the halt and drops busy. The bench expects that strobe to vanish: busy stays low afterwards and the settled supply is the first target. The same strobe, sent one cycle later, is expected to start a full power-off sequence of exactly two busy cycles. A second strobe sent in the middle of the ramp is judged the same way.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

   typedef enum logic [1:0] {
      SUP_OFF  = 2'd0,
      SUP_LOW  = 2'd1,
      SUP_HIGH = 2'd2,
      SUP_BAD  = 2'd3
   } supply_e;

   typedef enum logic [1:0] {
      SRC_STATIC = 2'd0,
      SRC_SW     = 2'd1,
      SRC_HW     = 2'd2,
      SRC_NONE   = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      DEC_HOLD = 2'd0,
      DEC_UP   = 2'd1,
      DEC_DOWN = 2'd2
   } dec_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_HALT   = 3'd1,
      ST_CUT    = 3'd2,
      ST_RAMP   = 3'd3,
      ST_RESUME = 3'd4
   } seq_st_e;

endpackage

// File: rtl/tpc_policy.sv
module tpc_policy
   import tpc_pkg::*;
#(
   parameter int WIN   = 256,
   parameter int FILLW = 7,
   parameter int DIVW  = 4,
   localparam int WINW = $clog2(WIN),
   localparam int CNTW = WINW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FILLW-1:0] fifo_fill,
   input  logic             core_stall,
   input  logic [FILLW-1:0] fill_hi_th,
   input  logic [FILLW-1:0] fill_lo_th,
   input  logic [CNTW-1:0]  stall_hi_th,
   input  logic [CNTW-1:0]  stall_lo_th,
   input  logic [DIVW-1:0]  fast_div,
   input  logic [DIVW-1:0]  slow_div,
   output logic             pol_valid,
   output logic [1:0]       pol_supply,
   output logic [DIVW-1:0]  pol_div
);

   generate
      if ((1 << WINW) != WIN) begin : g_bad_win
         $error("tpc_policy: WIN must be a power of two");
      end
      if (WIN < 4) begin : g_small_win
         $error("tpc_policy: WIN must be at least 4");
      end
   endgenerate

   logic [WINW-1:0] win_cnt;
   logic [CNTW-1:0] stall_cnt;
   logic [CNTW-1:0] stall_total;
   logic            win_end;
   dec_e            dec_now;
   dec_e            dec_prev;

   assign win_end     = (win_cnt == WINW'(WIN - 1));
   assign stall_total = stall_cnt + CNTW'(core_stall);

   always_comb begin
      if (fifo_fill > fill_hi_th || stall_total < stall_lo_th)
         dec_now = DEC_UP;
      else if (fifo_fill < fill_lo_th && stall_total > stall_hi_th)
         dec_now = DEC_DOWN;
      else
         dec_now = DEC_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt    <= '0;
         stall_cnt  <= '0;
         dec_prev   <= DEC_HOLD;
         pol_valid  <= 1'b0;
         pol_supply <= SUP_OFF;
         pol_div    <= '0;
      end else begin
         win_cnt   <= win_cnt + 1'b1;
         pol_valid <= 1'b0;
         if (win_end) begin
            stall_cnt <= '0;
            dec_prev  <= dec_now;
            if (dec_now == dec_prev && dec_now != DEC_HOLD) begin
               pol_valid  <= 1'b1;
               pol_supply <= (dec_now == DEC_UP) ? SUP_HIGH : SUP_LOW;
               pol_div    <= (dec_now == DEC_UP) ? fast_div : slow_div;
            end
         end else begin
            stall_cnt <= stall_total;
         end
      end
   end

   // R10: a policy request only ever follows a window close
   a_r10_after_window: assert property (@(posedge clk) disable iff (!rst_n)
      pol_valid |-> (win_cnt == '0));

endmodule

// File: rtl/tpc_src_mux.sv
module tpc_src_mux
   import tpc_pkg::*;
#(
   parameter int DIVW = 4
) (
   input  logic [1:0]      src_sel,
   input  logic [1:0]      static_supply,
   input  logic [DIVW-1:0] static_div,
   input  logic            sw_valid,
   input  logic [1:0]      sw_supply,
   input  logic [DIVW-1:0] sw_div,
   input  logic            pol_valid,
   input  logic [1:0]      pol_supply,
   input  logic [DIVW-1:0] pol_div,
   output logic            req_valid,
   output logic [1:0]      req_supply,
   output logic [DIVW-1:0] req_div
);

   logic raw_valid;

   always_comb begin
      unique case (src_e'(src_sel))
         SRC_STATIC: begin
            raw_valid  = 1'b1;
            req_supply = static_supply;
            req_div    = static_div;
         end
         SRC_SW: begin
            raw_valid  = sw_valid;
            req_supply = sw_supply;
            req_div    = sw_div;
         end
         SRC_HW: begin
            raw_valid  = pol_valid;
            req_supply = pol_supply;
            req_div    = pol_div;
         end
         default: begin
            raw_valid  = 1'b0;
            req_supply = SUP_OFF;
            req_div    = '0;
         end
      endcase
      req_valid = raw_valid && (req_supply != SUP_BAD);
   end

endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
   import tpc_pkg::*;
#(
   parameter int NSEG  = 48,
   parameter int STEPW = 8,
   parameter int DIVW  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_supply,
   input  logic [DIVW-1:0]  req_div,
   input  logic [STEPW-1:0] step_interval,
   output logic             rail_hi,
   output logic             rail_lo,
   output logic [NSEG-1:0]  gate_en,
   output logic             osc_halt,
   output logic [DIVW-1:0]  osc_div,
   output logic             busy,
   output logic [1:0]       supply_state
);

   generate
      if (NSEG < 2) begin : g_bad_nseg
         $error("tpc_seq: NSEG must be at least 2");
      end
      if (STEPW < 1 || DIVW < 1) begin : g_bad_width
         $error("tpc_seq: STEPW and DIVW must be positive");
      end
   endgenerate

   seq_st_e          st;
   supply_e          cur_sup;
   supply_e          tgt_sup;
   logic [DIVW-1:0]  tgt_div;
   logic [STEPW-1:0] step_cnt;
   logic [NSEG-1:0]  gate_q;
   logic             rail_hi_q;
   logic             rail_lo_q;
   logic             halt_q;
   logic [DIVW-1:0]  div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_sup   <= SUP_OFF;
         tgt_sup   <= SUP_OFF;
         tgt_div   <= '0;
         step_cnt  <= '0;
         gate_q    <= '0;
         rail_hi_q <= 1'b0;
         rail_lo_q <= 1'b0;
         halt_q    <= 1'b1;
         div_q     <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  if (supply_e'(req_supply) != cur_sup) begin
                     tgt_sup <= supply_e'(req_supply);
                     tgt_div <= req_div;
                     halt_q  <= 1'b1;
                     st      <= ST_HALT;
                  end else if (req_div != div_q) begin
                     div_q <= req_div;
                  end
               end
            end
            ST_HALT: begin
               gate_q    <= '0;
               rail_hi_q <= 1'b0;
               rail_lo_q <= 1'b0;
               st        <= ST_CUT;
            end
            ST_CUT: begin
               if (tgt_sup == SUP_OFF) begin
                  cur_sup <= SUP_OFF;
                  div_q   <= tgt_div;
                  st      <= ST_IDLE;
               end else begin
                  rail_hi_q <= (tgt_sup == SUP_HIGH);
                  rail_lo_q <= (tgt_sup == SUP_LOW);
                  step_cnt  <= '0;
                  st        <= ST_RAMP;
               end
            end
            ST_RAMP: begin
               if (step_cnt == step_interval) begin
                  step_cnt <= '0;
                  gate_q   <= {gate_q[NSEG-2:0], 1'b1};
                  if (gate_q[NSEG-2]) st <= ST_RESUME;
               end else begin
                  step_cnt <= step_cnt + 1'b1;
               end
            end
            ST_RESUME: begin
               halt_q  <= 1'b0;
               div_q   <= tgt_div;
               cur_sup <= tgt_sup;
               st      <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rail_hi      = rail_hi_q;
   assign rail_lo      = rail_lo_q;
   assign gate_en      = gate_q;
   assign osc_halt     = halt_q;
   assign osc_div      = div_q;
   assign busy         = (st != ST_IDLE);
   assign supply_state = cur_sup;

   // R5: both rails are never tied to the core at once
   a_r5_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rail_hi_q && rail_lo_q));

   // R5: no conducting segment without a selected rail
   a_r5_gates_need_rail: assert property (@(posedge clk) disable iff (!rst_n)
      (!rail_hi_q && !rail_lo_q) |-> (gate_q == '0));

   // R6: inrush limited to one new segment per cycle
   a_r6_one_segment: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate_q) <= $countones($past(gate_q)) + 1);

   // R11: rail selects only move while the clock is stopped
   a_r11_halt_on_rail_change: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_hi_q != $past(rail_hi_q) || rail_lo_q != $past(rail_lo_q))
         |-> (halt_q && $past(halt_q)));

   // R11: the clock restarts only on a fully closed gate
   a_r11_full_before_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_q) |-> (&gate_q));

   // R8: the running target never changes under a new request
   a_r8_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(tgt_sup) && $stable(tgt_div)));

endmodule

// File: rtl/tile_pwr_ctl.sv
module tile_pwr_ctl
   import tpc_pkg::*;
#(
   parameter int NSEG  = 48,
   parameter int DIVW  = 4,
   parameter int FILLW = 7,
   parameter int WIN   = 256,
   parameter int STEPW = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             src_sel,
   input  logic [1:0]             static_supply,
   input  logic [DIVW-1:0]        static_div,
   input  logic                   sw_valid,
   input  logic [1:0]             sw_supply,
   input  logic [DIVW-1:0]        sw_div,
   input  logic [FILLW-1:0]       fifo_fill,
   input  logic                   core_stall,
   input  logic [FILLW-1:0]       fill_hi_th,
   input  logic [FILLW-1:0]       fill_lo_th,
   input  logic [$clog2(WIN):0]   stall_hi_th,
   input  logic [$clog2(WIN):0]   stall_lo_th,
   input  logic [DIVW-1:0]        fast_div,
   input  logic [DIVW-1:0]        slow_div,
   input  logic [STEPW-1:0]       step_interval,
   output logic                   rail_hi,
   output logic                   rail_lo,
   output logic [NSEG-1:0]        gate_en,
   output logic                   osc_halt,
   output logic [DIVW-1:0]        osc_div,
   output logic                   busy,
   output logic [1:0]             supply_state
);

   logic            pol_valid;
   logic [1:0]      pol_supply;
   logic [DIVW-1:0] pol_div;
   logic            req_valid;
   logic [1:0]      req_supply;
   logic [DIVW-1:0] req_div;

   tpc_policy #(.WIN(WIN), .FILLW(FILLW), .DIVW(DIVW)) u_policy (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_fill   (fifo_fill),
      .core_stall  (core_stall),
      .fill_hi_th  (fill_hi_th),
      .fill_lo_th  (fill_lo_th),
      .stall_hi_th (stall_hi_th),
      .stall_lo_th (stall_lo_th),
      .fast_div    (fast_div),
      .slow_div    (slow_div),
      .pol_valid   (pol_valid),
      .pol_supply  (pol_supply),
      .pol_div     (pol_div)
   );

   tpc_src_mux #(.DIVW(DIVW)) u_mux (
      .src_sel       (src_sel),
      .static_supply (static_supply),
      .static_div    (static_div),
      .sw_valid      (sw_valid),
      .sw_supply     (sw_supply),
      .sw_div        (sw_div),
      .pol_valid     (pol_valid),
      .pol_supply    (pol_supply),
      .pol_div       (pol_div),
      .req_valid     (req_valid),
      .req_supply    (req_supply),
      .req_div       (req_div)
   );

   tpc_seq #(.NSEG(NSEG), .STEPW(STEPW), .DIVW(DIVW)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_supply    (req_supply),
      .req_div       (req_div),
      .step_interval (step_interval),
      .rail_hi       (rail_hi),
      .rail_lo       (rail_lo),
      .gate_en       (gate_en),
      .osc_halt      (osc_halt),
      .osc_div       (osc_div),
      .busy          (busy),
      .supply_state  (supply_state)
   );

   // R2: an invalid supply code never reaches the sequencer
   a_r2_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_supply != 2'd3));

endmodule

// File: tb/tile_pwr_ctl_test.sv
module tile_pwr_ctl_test;

   localparam int NSEG = 48;
   localparam int DIVW = 4;
   localparam int FILLW = 7;
   localparam int WIN = 256;
   localparam int STEPW = 8;
   localparam int CW = $clog2(WIN) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       src_sel = 2'd0;
   logic [1:0]       static_supply = 2'd0;
   logic [DIVW-1:0]  static_div = '0;
   logic             sw_valid = 1'b0;
   logic [1:0]       sw_supply = 2'd0;
   logic [DIVW-1:0]  sw_div = '0;
   logic [FILLW-1:0] fifo_fill = '0;
   logic             core_stall = 1'b0;
   logic [FILLW-1:0] fill_hi_th = 7'd48;
   logic [FILLW-1:0] fill_lo_th = 7'd16;
   logic [CW-1:0]    stall_hi_th = 9'd200;
   logic [CW-1:0]    stall_lo_th = 9'd20;
   logic [DIVW-1:0]  fast_div = 4'd1;
   logic [DIVW-1:0]  slow_div = 4'd7;
   logic [STEPW-1:0] step_interval = '0;
   logic             rail_hi, rail_lo, osc_halt, busy;
   logic [NSEG-1:0]  gate_en;
   logic [DIVW-1:0]  osc_div;
   logic [1:0]       supply_state;

   int tests = 0;
   int fails = 0;
   int edges = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   tile_pwr_ctl #(.NSEG(NSEG), .DIVW(DIVW), .FILLW(FILLW), .WIN(WIN), .STEPW(STEPW)) uut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .static_supply(static_supply),
      .static_div(static_div), .sw_valid(sw_valid), .sw_supply(sw_supply), .sw_div(sw_div),
      .fifo_fill(fifo_fill), .core_stall(core_stall), .fill_hi_th(fill_hi_th),
      .fill_lo_th(fill_lo_th), .stall_hi_th(stall_hi_th), .stall_lo_th(stall_lo_th),
      .fast_div(fast_div), .slow_div(slow_div), .step_interval(step_interval),
      .rail_hi(rail_hi), .rail_lo(rail_lo), .gate_en(gate_en), .osc_halt(osc_halt),
      .osc_div(osc_div), .busy(busy), .supply_state(supply_state));

   typedef struct packed {
      logic [1:0]  sup;
      logic [3:0]  div;
      logic [7:0]  intv;
      logic [15:0] cyc;
   } vec_t;

   // software-mode walk starting from power-off; cyc = expected busy cycles
   localparam vec_t VEC [6] = '{
      '{2'd2, 4'd1, 8'd0, 16'd51},
      '{2'd1, 4'd5, 8'd1, 16'd99},
      '{2'd1, 4'd9, 8'd1, 16'd0},
      '{2'd0, 4'd2, 8'd0, 16'd2},
      '{2'd1, 4'd3, 8'd2, 16'd147},
      '{2'd2, 4'd0, 8'd0, 16'd51}
   };

   task automatic check(input string req, input string what, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic sw_cmd(input logic [1:0] sup, input logic [DIVW-1:0] dv);
      sw_supply = sup;
      sw_div = dv;
      sw_valid = 1'b1;
      @(negedge clk);
      sw_valid = 1'b0;
   endtask

   // counts busy cycles; flags any busy cycle with the clock running
   task automatic wait_idle(output int n, output int halt_bad);
      n = 0;
      halt_bad = 0;
      while (busy && n < 20000) begin
         if (!osc_halt) halt_bad++;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic settled(input string req, input logic [1:0] sup, input logic [DIVW-1:0] dv);
      check(req, "supply_state", supply_state, sup);
      check(req, "osc_div", osc_div, dv);
      check(req, "osc_halt", osc_halt, sup == 2'd0);
      check(req, "gate count", $countones(gate_en), (sup == 2'd0) ? 0 : NSEG);
      check(req, "rails", {rail_hi, rail_lo}, {sup == 2'd2, sup == 2'd1});
   endtask

   task automatic run_quiet(input int cycles, output int saw);
      saw = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (busy) saw++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL R3 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n, hb, saw;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "supply", supply_state, 0);
      check("R1", "rails", {rail_hi, rail_lo}, 0);
      check("R1", "gates", gate_en, 0);
      check("R1", "halt", osc_halt, 1);
      check("R1", "div/busy", {osc_div, busy}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R2", "static equal: no busy", busy, 0);

      // R3 R4 R7: software table walk
      src_sel = 2'd1;
      for (int i = 0; i < 6; i++) begin
         step_interval = VEC[i].intv;
         sw_cmd(VEC[i].sup, VEC[i].div);
         wait_idle(n, hb);
         check(VEC[i].cyc == 0 ? "R7" : (VEC[i].sup == 0 ? "R4" : "R3"), "busy cycles", n, VEC[i].cyc);
         check("R11", "halt during transition", hb, 0);
         settled(VEC[i].cyc == 0 ? "R7" : "R3", VEC[i].sup, VEC[i].div);
      end

      // R2: invalid supply code dropped
      sw_cmd(2'd3, 4'd4);
      check("R2", "bad code busy", busy, 0);
      settled("R2", 2'd2, 4'd0);

      // R8: strobes mid-ramp and on the settling edge are dropped
      step_interval = 0;
      sw_cmd(2'd1, 4'd4);
      n = 0;
      sw_supply = 2'd0;
      sw_div = 4'd8;
      while (busy && n < 1000) begin
         sw_valid = (n == 5 || n == 50);
         n++;
         @(negedge clk);
      end
      sw_valid = 1'b0;
      check("R8", "busy cycles with strobes", n, 51);
      run_quiet(4, saw);
      check("R8", "no queued start", saw, 0);
      settled("R8", 2'd1, 4'd4);
      sw_cmd(2'd0, 4'd8);
      wait_idle(n, hb);
      check("R8", "strobe after settle accepted", n, 2);
      settled("R4", 2'd0, 4'd8);

      // R2: static source applied continuously
      static_supply = 2'd2;
      static_div = 4'd6;
      src_sel = 2'd0;
      @(negedge clk);
      wait_idle(n, hb);
      check("R2", "static busy cycles", n, 51);
      settled("R2", 2'd2, 4'd6);
      static_supply = 2'd1;
      static_div = 4'd2;
      @(negedge clk);
      wait_idle(n, hb);
      settled("R2", 2'd1, 4'd2);

      // hardware policy, fresh window alignment
      src_sel = 2'd2;
      rst_n = 1'b0;
      fifo_fill = 7'd60;
      core_stall = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      run_quiet(400, saw);
      check("R10", "one window no start", saw, 0);
      check("R10", "still off", supply_state, 0);
      n = 0;
      while (!busy && n < 400) begin n++; @(negedge clk); end
      check("R10", "second window starts", busy, 1);
      wait_idle(n, hb);
      settled("R9", 2'd2, 4'd1);

      // R2: software ignored in hardware mode
      sw_cmd(2'd0, 4'd3);
      run_quiet(3, saw);
      check("R2", "sw in hw mode", saw, 0);

      // R10: alternating UP/DOWN windows never confirm
      saw = 0;
      for (int i = 0; i < 4 * WIN; i++) begin
         fifo_fill = (((edges / WIN) % 2) != 0) ? 7'd60 : 7'd0;
         @(negedge clk);
         if (busy) saw++;
      end
      check("R10", "alternating no start", saw, 0);
      check("R10", "alternating state", supply_state, 2);

      // R9: DOWN by low fill and heavy stalls
      fifo_fill = 7'd0;
      n = 0;
      while (!busy && n < 4 * WIN) begin n++; @(negedge clk); end
      wait_idle(n, hb);
      settled("R9", 2'd1, 4'd7);

      // R9: hold zone leaves state alone
      fifo_fill = 7'd32;
      saw = 0;
      for (int i = 0; i < 3 * WIN; i++) begin
         core_stall = i[0];
         @(negedge clk);
         if (busy) saw++;
      end
      check("R9", "hold no start", saw, 0);
      check("R9", "hold state", supply_state, 1);

      // R9: UP by low stall count
      core_stall = 1'b0;
      n = 0;
      while (!busy && n < 4 * WIN) begin n++; @(negedge clk); end
      wait_idle(n, hb);
      settled("R9", 2'd2, 4'd1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule